// File: doc/BRIEF.md
# UTF-16 Surrogate Repair Stream Unit

This block sits in a streaming datapath that carries UTF-16 text as beats of `LANES` sixteen-bit code units. It accepts beats with a valid/ready handshake and a marker on the final beat of each stream. It returns exactly the same units, in the same order and grouped into the same beats. There is one change: any surrogate that does not belong to a properly ordered high-then-low pair is overwritten with the replacement character 0xFFFD. Non-surrogate units and correctly paired surrogates leave the block untouched.

Every lane is judged against its neighbour on each side. At a beat boundary the missing neighbour comes from the adjacent beat. The block therefore keeps one accepted beat in a holding stage until the first unit of the following beat is visible. The exception is a beat flagged as last, which needs no lookahead and moves on at once. All lanes of a beat are classified in parallel. When no lane and neither boundary shows a mismatch, the beat takes a pass-through path without any blending. Each output beat carries a per-lane repair mask. A sticky error flag reports whether the current stream has needed any repair so far.

Top module: `utf16_surrogate_repair`

## Requirements
- R1: A unit is a high surrogate exactly when (unit AND 0xFC00) = 0xD800 and a low surrogate exactly when (unit AND 0xFC00) = 0xDC00. Values just outside these ranges, such as 0xD7FF and 0xE000, are ordinary units.
- R2: A high surrogate whose next unit in the stream is not a low surrogate is output as 0xFFFD. A repaired high never prevents the following high from pairing with its own low.
- R3: A low surrogate whose previous unit in the stream (judged on the input values) is not a high surrogate is output as 0xFFFD. This includes a low surrogate in the first unit of a stream.
- R4: Ordinary units, and both halves of a high-low pair, are output unchanged. This holds also when the pair is split across two beats.
- R5: A high surrogate in the last unit of a stream is output as 0xFFFD. Units of the following stream are never paired with units of the previous one.
- R6: `out_fix_mask` bit i is 1 exactly when lane i of that output beat was replaced. Lane i occupies `out_data[16*i+15:16*i]`, and lane 0 is the earliest unit in stream order.
- R7: `err_flag` changes only when a new output beat is loaded. It then equals the OR of the repair masks of all beats of that stream up to and including this one, so it clears on the first beat of a new stream that needs no repair.
- R8: Every input beat appears exactly once at the output, in order, with `out_last` set on the beat that carried `in_last`. While `out_valid` is high and `out_ready` is low, the output beat holds steady.
- R9: After reset, `out_valid` and `err_flag` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat this cycle |
| in_data | input | LANES*16 | Input code units, lane 0 in the low bits |
| in_last | input | 1 | Input beat ends the stream |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | LANES*16 | Repaired code units, lane 0 in the low bits |
| out_last | output | 1 | Output beat ends the stream |
| out_fix_mask | output | LANES | Per-lane flag: lane was replaced |
| err_flag | output | 1 | Some unit of the current stream has been replaced |

## Verification
Internal state in this block is small: the lookback bit stored with the held beat, the held beat itself, and the stream-start marker. Each has a clear signature at the ports. A wrong lookback bit shows up in lane 0 of the next emitted beat. It appears either as a spurious 0xFFFD or as a lone low that escapes repair, together with a matching error in the mask bit. A held beat that is lost or repeated breaks the ordering of units, and the first affected output beat mismatches. A stale stream-start marker leaves `err_flag` set on a clean beat that opens a new stream. An exhaustive sweep over two-beat streams of plain, high and low units reaches every boundary case within one or two output beats of the fault.

// File: rtl/utf16_fix_pkg.sv
package utf16_fix_pkg;

    localparam int          UNIT_W   = 16;
    localparam logic [15:0] SUR_MASK = 16'hFC00;
    localparam logic [15:0] HI_TAG   = 16'hD800;
    localparam logic [15:0] LO_TAG   = 16'hDC00;
    localparam logic [15:0] REPL     = 16'hFFFD;

    typedef enum logic [1:0] {
        CLS_PLAIN = 2'd0,
        CLS_HIGH  = 2'd1,
        CLS_LOW   = 2'd2
    } unit_cls_e;

    function automatic unit_cls_e classify(input logic [15:0] u);
        if ((u & SUR_MASK) == HI_TAG)      return CLS_HIGH;
        else if ((u & SUR_MASK) == LO_TAG) return CLS_LOW;
        else                               return CLS_PLAIN;
    endfunction

    function automatic logic is_high(input logic [15:0] u);
        return classify(u) == CLS_HIGH;
    endfunction

    function automatic logic is_low(input logic [15:0] u);
        return classify(u) == CLS_LOW;
    endfunction

endpackage

// File: rtl/u16_classify.sv
module u16_classify
    import utf16_fix_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*UNIT_W-1:0] units,
    output logic [LANES-1:0]        hi_vec,
    output logic [LANES-1:0]        lo_vec
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        unit_cls_e cls;
        assign cls       = classify(units[i*UNIT_W +: UNIT_W]);
        assign hi_vec[i] = (cls == CLS_HIGH);
        assign lo_vec[i] = (cls == CLS_LOW);
    end
endmodule

// File: rtl/u16_repair_mask.sv
module u16_repair_mask #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] hi_vec,
    input  logic [LANES-1:0] lo_vec,
    input  logic             prev_hi,
    input  logic             next_lo,
    output logic [LANES-1:0] fix_mask,
    output logic             clean
);
    logic [LANES-1:0] lb_hi;
    logic [LANES-1:0] nx_lo;

    for (genvar i = 0; i < LANES; i++) begin : g_nbr
        if (i == 0) begin : g_first
            assign lb_hi[i] = prev_hi;
        end else begin : g_mid_lb
            assign lb_hi[i] = hi_vec[i-1];
        end
        if (i == LANES - 1) begin : g_lastl
            assign nx_lo[i] = next_lo;
        end else begin : g_mid_nx
            assign nx_lo[i] = lo_vec[i+1];
        end
    end

    logic [LANES-1:0] hi_err;
    logic [LANES-1:0] lo_err;

    assign hi_err   = hi_vec & ~nx_lo;
    assign lo_err   = lo_vec & ~lb_hi;
    assign fix_mask = hi_err | lo_err;

    assign clean = (({hi_vec[LANES-1], lb_hi} ^ {next_lo, lo_vec}) == '0);
endmodule

// File: rtl/u16_lane_blend.sv
module u16_lane_blend
    import utf16_fix_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*UNIT_W-1:0] din,
    input  logic [LANES-1:0]        fix_mask,
    input  logic                    clean,
    output logic [LANES*UNIT_W-1:0] dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[i*UNIT_W +: UNIT_W] = (!clean && fix_mask[i]) ? REPL
                                          : din[i*UNIT_W +: UNIT_W];
    end
endmodule

// File: rtl/utf16_surrogate_repair.sv
module utf16_surrogate_repair
    import utf16_fix_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*UNIT_W-1:0] in_data,
    input  logic                    in_last,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*UNIT_W-1:0] out_data,
    output logic                    out_last,
    output logic [LANES-1:0]        out_fix_mask,
    output logic                    err_flag
);
    localparam int W = LANES * UNIT_W;

    typedef struct packed {
        logic [W-1:0] data;
        logic         last;
        logic         first;
        logic         prev_hi;
    } hold_t;

    hold_t            hold_q;
    hold_t            hold_d;
    logic             hold_vld;
    logic [LANES-1:0] h_hi;
    logic [LANES-1:0] h_lo;
    logic [LANES-1:0] fix_mask;
    logic             clean;
    logic [W-1:0]     fixed;
    logic             next_lo;
    logic             o_free;
    logic             advance;
    logic             take;
    logic             mid_stream;

    logic             o_vld;
    logic [W-1:0]     o_data;
    logic [LANES-1:0] o_mask;
    logic             o_last;
    logic             err_q;

    u16_classify #(.LANES(LANES)) u_cls (
        .units  (hold_q.data),
        .hi_vec (h_hi),
        .lo_vec (h_lo)
    );

    assign next_lo = !hold_q.last && is_low(in_data[UNIT_W-1:0]);

    u16_repair_mask #(.LANES(LANES)) u_mask (
        .hi_vec   (h_hi),
        .lo_vec   (h_lo),
        .prev_hi  (hold_q.prev_hi),
        .next_lo  (next_lo),
        .fix_mask (fix_mask),
        .clean    (clean)
    );

    u16_lane_blend #(.LANES(LANES)) u_blend (
        .din      (hold_q.data),
        .fix_mask (fix_mask),
        .clean    (clean),
        .dout     (fixed)
    );

    assign o_free     = !o_vld || out_ready;
    assign advance    = hold_vld && (hold_q.last || in_valid) && o_free;
    assign in_ready   = !hold_vld || advance;
    assign take       = in_valid && in_ready;
    assign mid_stream = hold_vld && !hold_q.last;

    always_comb begin
        hold_d.data    = in_data;
        hold_d.last    = in_last;
        hold_d.first   = !mid_stream;
        hold_d.prev_hi = mid_stream && h_hi[LANES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld <= 1'b0;
            hold_q   <= '0;
        end else if (take) begin
            hold_vld <= 1'b1;
            hold_q   <= hold_d;
        end else if (advance) begin
            hold_vld <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld  <= 1'b0;
            o_data <= '0;
            o_mask <= '0;
            o_last <= 1'b0;
            err_q  <= 1'b0;
        end else if (advance) begin
            o_vld  <= 1'b1;
            o_data <= fixed;
            o_mask <= fix_mask;
            o_last <= hold_q.last;
            err_q  <= hold_q.first ? (|fix_mask) : (err_q || (|fix_mask));
        end else if (out_ready) begin
            o_vld  <= 1'b0;
        end
    end

    assign out_valid    = o_vld;
    assign out_data     = o_data;
    assign out_fix_mask = o_mask;
    assign out_last     = o_last;
    assign err_flag     = err_q;
endmodule

// File: rtl/utf16_repair_chk.sv
module utf16_repair_chk
    import utf16_fix_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LANES*UNIT_W-1:0] out_data,
    input logic                    out_last,
    input logic [LANES-1:0]        out_fix_mask,
    input logic                    err_flag
);
    function automatic logic masked_are_repl(input logic [LANES*UNIT_W-1:0] d,
                                             input logic [LANES-1:0] m);
        for (int i = 0; i < LANES; i++)
            if (m[i] && d[i*UNIT_W +: UNIT_W] != REPL) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic highs_paired(input logic [LANES*UNIT_W-1:0] d);
        for (int i = 0; i < LANES - 1; i++)
            if (is_high(d[i*UNIT_W +: UNIT_W]) && !is_low(d[(i+1)*UNIT_W +: UNIT_W]))
                return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic lows_paired(input logic [LANES*UNIT_W-1:0] d);
        for (int i = 1; i < LANES; i++)
            if (is_low(d[i*UNIT_W +: UNIT_W]) && !is_high(d[(i-1)*UNIT_W +: UNIT_W]))
                return 1'b0;
        return 1'b1;
    endfunction

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_fix_mask) && $stable(out_last));

    assert_mask_lanes_repl_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> masked_are_repl(out_data, out_fix_mask));

    assert_no_lone_high_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> highs_paired(out_data));

    assert_no_lone_low_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> lows_paired(out_data));

    assert_err_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> out_valid && (out_fix_mask != '0));
endmodule

bind utf16_surrogate_repair utf16_repair_chk #(.LANES(LANES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_last     (out_last),
    .out_fix_mask (out_fix_mask),
    .err_flag     (err_flag)
);

// File: tb/sim_utf16_surrogate_repair.sv
module sim_utf16_surrogate_repair;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int W          = LANES * 16;
    localparam int MAXU       = 16;
    localparam int WDOG       = 180000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [W-1:0]     in_data = '0;
    logic             in_last = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [W-1:0]     out_data;
    logic             out_last;
    logic [LANES-1:0] out_fix_mask;
    logic             err_flag;

    int compared   = 0;
    int mismatched = 0;
    bit reported   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    utf16_surrogate_repair #(.LANES(LANES)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_fix_mask(out_fix_mask), .err_flag(err_flag)
    );

    logic [W-1:0]     q_in[$];
    logic [W-1:0]     q_data[$];
    logic [LANES-1:0] q_mask[$];
    bit               q_last[$];
    bit               q_err[$];

    bit [15:0] su [0:MAXU-1];
    int        nb;

    function automatic bit hi16(bit [15:0] u); return (u & 16'hFC00) == 16'hD800; endfunction
    function automatic bit lo16(bit [15:0] u); return (u & 16'hFC00) == 16'hDC00; endfunction
    function automatic bit edge16(bit [15:0] u);
        return u == 16'hD7FF || u == 16'hD800 || u == 16'hDBFF ||
               u == 16'hDC00 || u == 16'hDFFF || u == 16'hE000;
    endfunction

    function automatic bit [15:0] sym_val(int sym, int k);
        bit [15:0] plain [0:5];
        plain[0] = 16'h0041; plain[1] = 16'hD7FF; plain[2] = 16'hE000;
        plain[3] = 16'h0000; plain[4] = 16'hFFFF; plain[5] = 16'hFC00;
        if (sym == 1) return 16'hD800 | 16'((k * 97) & 16'h3FF);
        if (sym == 2) return 16'hDC00 | 16'((k * 53) & 16'h3FF);
        return plain[k % 6];
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // scalar reference and driver for one stream held in su[0 .. nb*LANES-1]
    task automatic run_stream();
        int        n;
        bit [15:0] r [0:MAXU-1];
        bit        m [0:MAXU-1];
        bit        err;
        n   = nb * LANES;
        err = 0;
        for (int i = 0; i < n; i++) begin
            bit bad;
            bad = 0;
            if (hi16(su[i]) && !(i + 1 < n && lo16(su[i+1]))) bad = 1;
            if (lo16(su[i]) && !(i > 0 && hi16(su[i-1])))     bad = 1;
            m[i] = bad;
            r[i] = bad ? 16'hFFFD : su[i];
        end
        for (int b = 0; b < nb; b++) begin
            logic [W-1:0]     bi, bd;
            logic [LANES-1:0] bm;
            for (int l = 0; l < LANES; l++) begin
                bi[l*16 +: 16] = su[b*LANES + l];
                bd[l*16 +: 16] = r[b*LANES + l];
                bm[l]          = m[b*LANES + l];
            end
            err = err | (bm != '0);
            q_in.push_back(bi);
            q_data.push_back(bd);
            q_mask.push_back(bm);
            q_last.push_back(b == nb - 1);
            q_err.push_back(err);
        end
        for (int b = 0; b < nb; b++) begin
            logic [W-1:0] bi;
            for (int l = 0; l < LANES; l++) bi[l*16 +: 16] = su[b*LANES + l];
            if ($urandom % 6 == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = bi;
            in_last  = (b == nb - 1);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
    endtask

    // output monitor
    initial begin
        forever begin
            @(negedge clk);
            out_ready = rst ? 1'b0 : (($urandom % 4) != 0);
            #2;
            if (!rst && out_valid && out_ready) begin
                if (q_data.size() == 0) begin
                    check(0, "R8 unexpected beat", out_data, 0);
                end else begin
                    logic [W-1:0]     ei, ed;
                    logic [LANES-1:0] em;
                    bit               el, ee;
                    ei = q_in.pop_front();
                    ed = q_data.pop_front();
                    em = q_mask.pop_front();
                    el = q_last.pop_front();
                    ee = q_err.pop_front();
                    for (int l = 0; l < LANES; l++) begin
                        bit [15:0] o;
                        string     tag;
                        o = ei[l*16 +: 16];
                        if (edge16(o))                                      tag = "R1 range edge";
                        else if (el && l == LANES - 1 && hi16(o))           tag = "R5 final high";
                        else if (em[l] && hi16(o))                          tag = "R2 lone high";
                        else if (em[l] && lo16(o))                          tag = "R3 lone low";
                        else                                                tag = "R4 pass-through";
                        check(out_data[l*16 +: 16] == ed[l*16 +: 16], tag,
                              64'(out_data[l*16 +: 16]), 64'(ed[l*16 +: 16]));
                    end
                    check(out_fix_mask == em, "R6 repair mask", 64'(out_fix_mask), 64'(em));
                    check(out_last == el, "R8 last marker", 64'(out_last), 64'(el));
                    check(err_flag == ee, "R7 sticky error", 64'(err_flag), 64'(ee));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (WDOG) @(posedge clk);
        mismatched++;
        $display("FAIL R8 watchdog expired: %0d beats outstanding, expected 0", q_data.size());
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check(out_valid == 1'b0, "R9 reset out_valid", 64'(out_valid), 0);
        check(err_flag == 1'b0,  "R9 reset err_flag",  64'(err_flag), 0);
        check(in_ready == 1'b1,  "R9 reset in_ready",  64'(in_ready), 1);

        // directed: range edges, lone low first, final high, straddling pair
        su[0] = 16'hD7FF; su[1] = 16'hDBFF; su[2] = 16'hDC00; su[3] = 16'hE000;
        nb = 1; run_stream();
        su[0] = 16'hDFFF; su[1] = 16'hD800; su[2] = 16'hDFFF; su[3] = 16'hD800;
        nb = 1; run_stream();
        su[0] = 16'h0041; su[1] = 16'hD800; su[2] = 16'hD801; su[3] = 16'hDBFF;
        su[4] = 16'hDC00; su[5] = 16'hDC01; su[6] = 16'h0042; su[7] = 16'hE000;
        nb = 2; run_stream();
        su[0] = 16'hDC00; su[1] = 16'h0041; su[2] = 16'h0041; su[3] = 16'h0041;
        nb = 1; run_stream();

        // exhaustive: all two-beat streams over {plain, high, low}
        for (int s = 0; s < 6561; s++) begin
            int t;
            t = s;
            for (int p = 0; p < 2 * LANES; p++) begin
                su[p] = sym_val(t % 3, s * 8 + p);
                t = t / 3;
            end
            nb = 2;
            run_stream();
        end

        // random streams of one to four beats
        for (int s = 0; s < 300; s++) begin
            nb = 1 + int'($urandom % 4);
            for (int p = 0; p < nb * LANES; p++)
                su[p] = sym_val(int'($urandom % 4) % 3, int'($urandom % 4096));
            run_stream();
        end

        @(negedge clk);
        in_valid = 1'b0;
        while (q_data.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R8 no extra beats", 64'(out_valid), 0);
        report();
    end
endmodule